// File: doc/BRIEF.md
# Single-Wire Search Accelerator Sequencer

This block runs the ROM search inside a single-wire bus master. The host first issues a bus reset and the search command byte. It then raises the enable input and writes sixteen bytes. Each written byte starts one exchange of four search steps.

A step consists of two read slots and one write slot. The first read slot returns the ROM bit that all responding devices share. The second read slot returns its complement. The write slot drives the direction the step resolved to. After the fourth step, the block returns one byte. That byte pairs each resolved ROM bit with a flag that marks a discrepancy. The nibble of resolved bits from exchange i holds identifier bits 4i to 4i+3, so sixteen exchanges collect the whole 64-bit identifier.

The block does not time the bus slots itself. It asks an external slot generator for each slot and waits for that generator's acknowledge. Lowering the enable returns the master to plain byte mode.

Top module: `onewire_search_seq`

## Requirements
- R1: With the enable high and no exchange running, a high `in_valid` latches `in_byte` and starts an exchange; a read slot is requested in the next cycle. `in_valid` is ignored while an exchange runs or while the enable is low.
- R2: Each step requests, in order, a read slot, a second read slot and a write slot (`slot_write` 0 = read, 1 = write). `slot_req`, `slot_write` and `slot_wbit` stay unchanged until `slot_ack` closes the slot.
- R3: First read 0 then second read 1 resolves the bit to 0. First read 1 then second read 0 resolves it to 1. In both cases the discrepancy flag is 0.
- R4: Two reads of 0 set the discrepancy flag. For step k (0..3) the resolved bit is then taken from bit 2k+1 of the byte that started the exchange. A written 0x00 therefore takes the zero branch at every discrepancy.
- R5: Two reads of 1 mean no device answered. The step resolves to 1 with the flag set, and `nodev_err` goes high and stays high while the enable is held.
- R6: The write slot of each step drives the resolved bit on `slot_wbit`.
- R7: In the returned byte, bit 2k+1 holds the resolved bit of step k and bit 2k holds its discrepancy flag, with step 0 first.
- R8: `out_valid` is high for exactly one cycle, the cycle after the acknowledge of the fourth write slot. `out_byte` holds its value until the next exchange completes.
- R9: Lowering the enable abandons any exchange. The request drops in the next cycle, no completion is reported, and `nodev_err` clears.
- R10: Sixteen exchanges with 0x00 return the identifier of the device that holds 0 at the first discrepancy. Sixteen exchanges with 0xAA return the identifier of the device that holds 1 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Search accelerator enable |
| in_valid | input | 1 | Host byte strobe |
| in_byte | input | 2*STEPS | Host byte; bit 2k+1 is the branch choice for step k |
| out_valid | output | 1 | Exchange complete strobe |
| out_byte | output | 2*STEPS | Resolved bits (odd positions) and discrepancy flags (even positions) |
| nodev_err | output | 1 | Sticky no-response indication |
| slot_req | output | 1 | Bit-slot request |
| slot_write | output | 1 | Requested slot kind: 0 read, 1 write |
| slot_wbit | output | 1 | Bit to drive in a write slot |
| slot_ack | input | 1 | Slot finished |
| slot_rbit | input | 1 | Bus value sampled in a read slot |

## Verification
Some properties are checked by assertions on every cycle:
- the slot request stays stable until it is acknowledged;
- the request drops after the enable falls;
- the error flag is sticky, and clears with the enable;
- completion is a single-cycle pulse that follows a write-slot acknowledge.

Other behaviour only the bench scenarios can show. This covers how the two read results resolve a bit, the packing of bits and flags in the returned byte, and the branch taken from the host byte. It also covers the walk of a whole identifier against a model of two devices, and the cases of no device and an aborted exchange.

// File: rtl/onewire_search_seq.sv
module onewire_search_seq #(
  parameter int STEPS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               in_valid,
  input  logic [2*STEPS-1:0] in_byte,
  output logic               out_valid,
  output logic [2*STEPS-1:0] out_byte,
  output logic               nodev_err,
  output logic               slot_req,
  output logic               slot_write,
  output logic               slot_wbit,
  input  logic               slot_ack,
  input  logic               slot_rbit
);
  localparam int BW = 2 * STEPS;
  localparam int IW = (BW > 2) ? $clog2(BW) : 1;
  localparam logic [IW-1:0] LAST = IW'(BW - 2);

  typedef enum logic [1:0] {IDLE, RD_A, RD_B, WR} st_t;

  st_t st;
  logic [BW-1:0] choice, acc;
  logic [IW-1:0] bi;
  logic first, res;

  wire both0   = !first && !slot_rbit;
  wire same    = first == slot_rbit;
  wire pick    = choice[bi | IW'(1)];
  wire res_nxt = both0 ? pick : first;

  assign slot_req   = st != IDLE;
  assign slot_write = st == WR;
  assign slot_wbit  = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      choice    <= '0;
      acc       <= '0;
      bi        <= '0;
      first     <= 1'b0;
      res       <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      nodev_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!acc_en) begin
        st        <= IDLE;
        nodev_err <= 1'b0;
      end else begin
        case (st)
          IDLE: if (in_valid) begin
            choice <= in_byte;
            bi     <= '0;
            st     <= RD_A;
          end
          RD_A: if (slot_ack) begin
            first <= slot_rbit;
            st    <= RD_B;
          end
          RD_B: if (slot_ack) begin
            res              <= res_nxt;
            acc[bi]          <= same;
            acc[bi | IW'(1)] <= res_nxt;
            if (first && slot_rbit) nodev_err <= 1'b1;
            st <= WR;
          end
          WR: if (slot_ack) begin
            if (bi == LAST) begin
              st        <= IDLE;
              out_valid <= 1'b1;
              out_byte  <= acc;
            end else begin
              bi <= bi + IW'(2);
              st <= RD_A;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/onewire_search_seq_chk.sv
module onewire_search_seq_chk #(
  parameter int STEPS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_en,
  input logic               in_valid,
  input logic [2*STEPS-1:0] in_byte,
  input logic               out_valid,
  input logic [2*STEPS-1:0] out_byte,
  input logic               nodev_err,
  input logic               slot_req,
  input logic               slot_write,
  input logic               slot_wbit,
  input logic               slot_ack,
  input logic               slot_rbit
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && slot_req && !slot_ack) |=> (slot_req && $stable(slot_write) && $stable(slot_wbit))); // R2

  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (!slot_req && !out_valid)); // R9

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !nodev_err); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && nodev_err) |=> nodev_err); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(slot_req && slot_write && slot_ack)); // R8
endmodule

bind onewire_search_seq onewire_search_seq_chk #(.STEPS(STEPS)) u_chk (.*);

// File: tb/onewire_search_seq_test.sv
module onewire_search_seq_test;
  localparam int CLK_NS = 10;
  localparam int DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic out_valid, nodev_err, slot_req, slot_write, slot_wbit;
  logic [7:0] out_byte;
  logic slot_ack = 1'b0, slot_rbit = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  onewire_search_seq #(.STEPS(4)) uut (.*);

  int vectors = 0, fails = 0, cyc = 0;

  // device model
  bit [63:0] rom [2];
  bit act [2];
  int bitpos;
  bit rd2;
  bit pend;
  int cnt;

  // reference model
  int m_ph, m_k;
  bit m_a, m_res, m_flag;
  bit [7:0] m_choice, m_acc, exp_ob;
  bit exp_ov, exp_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_a = 0; m_res = 0; m_choice = 0; m_acc = 0;
      exp_ob = 0; exp_ov = 0; exp_err = 0;
    end else begin
      exp_ov = 0;
      if (!acc_en) begin
        m_ph = 0; exp_err = 0;
      end else begin
        case (m_ph)
          0: if (in_valid) begin m_choice = in_byte; m_acc = 0; m_k = 0; m_ph = 1; end
          1: if (slot_ack) begin m_a = slot_rbit; m_ph = 2; end
          2: if (slot_ack) begin
               if (!m_a && slot_rbit) begin m_res = 0; m_flag = 0; end
               else if (m_a && !slot_rbit) begin m_res = 1; m_flag = 0; end
               else if (!m_a && !slot_rbit) begin m_res = m_choice[2*m_k+1]; m_flag = 1; end
               else begin m_res = 1; m_flag = 1; exp_err = 1; end
               m_acc[2*m_k] = m_flag;
               m_acc[2*m_k+1] = m_res;
               m_ph = 3;
             end
          3: if (slot_ack) begin
               if (m_k == 3) begin m_ph = 0; exp_ov = 1; exp_ob = m_acc; end
               else begin m_k++; m_ph = 1; end
             end
          default: m_ph = 0;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic reset_devs(input int n);
    for (int d = 0; d < 2; d++) act[d] = (d < n);
    bitpos = 0; rd2 = 0;
  endtask

  task automatic tick();
    bit v;
    @(posedge clk);
    @(negedge clk);
    chk(slot_req == (m_ph != 0), "R2 slot_req", slot_req, m_ph != 0);
    chk(slot_write == (m_ph == 3), "R2 slot_write", slot_write, m_ph == 3);
    if (m_ph == 3) chk(slot_wbit == m_res, "R6 slot_wbit", slot_wbit, m_res);
    chk(out_valid == exp_ov, "R8 out_valid", out_valid, exp_ov);
    chk(out_byte == exp_ob, "R7 out_byte", out_byte, exp_ob);
    chk(nodev_err == exp_err, "R5 nodev_err", nodev_err, exp_err);
    slot_ack = 0;
    if (!slot_req) pend = 0;
    else begin
      if (!pend) begin pend = 1; cnt = DLY; end
      if (cnt == 0) begin
        slot_ack = 1; pend = 0;
        if (!slot_write) begin
          v = 1;
          for (int d = 0; d < 2; d++)
            if (act[d]) v &= rd2 ? ~rom[d][bitpos & 63] : rom[d][bitpos & 63];
          slot_rbit = v; rd2 = !rd2;
        end else begin
          for (int d = 0; d < 2; d++)
            if (act[d] && rom[d][bitpos & 63] != slot_wbit) act[d] = 0;
          bitpos++; rd2 = 0;
        end
      end else cnt--;
    end
  endtask

  task automatic exchange(input bit [7:0] b, input bit poke, output bit [7:0] got);
    in_valid = 1; in_byte = b;
    tick();
    in_valid = 0;
    got = 8'hxx;
    for (int i = 0; i < 200; i++) begin
      if (poke && i == 3) begin in_valid = 1; in_byte = ~b; end
      tick();
      in_valid = 0;
      if (out_valid) begin got = out_byte; break; end
    end
  endtask

  task automatic walk(input bit [7:0] b, output bit [63:0] id, output bit [7:0] first_b);
    bit [7:0] g;
    reset_devs(2);
    id = '0;
    for (int i = 0; i < 16; i++) begin
      exchange(b, 0, g);
      if (i == 0) first_b = g;
      for (int k = 0; k < 4; k++) id[4*i+k] = g[2*k+1];
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] g, fb;
    bit [63:0] id;
    rom[0] = 64'hA5C3_0F1E_2D3C_4B28;
    rom[1] = rom[0] ^ 64'h0000_0100_0000_0004;
    reset_devs(2);
    pend = 0; cnt = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(!slot_req && !out_valid && out_byte == 0 && !nodev_err, "R1 reset state", slot_req, 0);

    // R1: strobe with enable low is ignored
    in_valid = 1; in_byte = 8'h00;
    tick();
    in_valid = 0;
    tick();
    chk(slot_req == 0, "R1 ignored while disabled", slot_req, 0);

    acc_en = 1;
    tick();
    // R3: single device, low nibble 1000b -> 0x80
    reset_devs(1);
    exchange(8'h00, 0, g);
    chk(g == 8'h80, "R3 single device byte", g, 8'h80);

    // R1: strobe during an exchange is ignored
    reset_devs(2);
    exchange(8'h00, 1, g);
    chk(g == 8'h90, "R1 busy strobe ignored", g, 8'h90);

    // R10 / R4: zero-branch pass
    walk(8'h00, id, fb);
    chk(fb == 8'h90, "R4 zero branch first byte", fb, 8'h90);
    chk(id == rom[0], "R10 zero-branch identifier", id[31:0], rom[0][31:0]);
    chk(id[63:32] == rom[0][63:32], "R10 zero-branch identifier high", id[63:32], rom[0][63:32]);

    // R4: one-branch pass
    walk(8'hAA, id, fb);
    chk(fb == 8'hB0, "R4 one branch first byte", fb, 8'hB0);
    chk(id == rom[1], "R10 one-branch identifier", id[31:0], rom[1][31:0]);

    // R5: no device answers
    reset_devs(0);
    exchange(8'h00, 0, g);
    chk(g == 8'hFF, "R5 no-device byte", g, 8'hFF);
    chk(nodev_err == 1, "R5 error set", nodev_err, 1);
    exchange(8'h00, 0, g);
    chk(nodev_err == 1, "R5 error sticky", nodev_err, 1);

    // R9: abort mid exchange
    reset_devs(2);
    in_valid = 1; in_byte = 8'h00;
    tick();
    in_valid = 0;
    repeat (5) tick();
    acc_en = 0;
    tick();
    chk(slot_req == 0, "R9 request dropped", slot_req, 0);
    chk(nodev_err == 0, "R9 error cleared", nodev_err, 0);
    for (int i = 0; i < 20; i++) begin
      tick();
      if (out_valid) chk(0, "R9 no completion", 1, 0);
    end
    acc_en = 1;
    reset_devs(1);
    tick();
    exchange(8'h00, 0, g);
    chk(g == 8'h80, "R9 clean restart", g, 8'h80);

    repeat (4) tick();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule